// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is the bus-side command decoder of a parallel NOR flash device. A host issues single-cycle writes: an address and a data byte, qualified by a write strobe. From these writes the block recognises three command sequences. The first programs a single word. The second is a buffered write that carries up to sixteen words under one confirm. The third is a two-step erase of the whole array.

The block keeps a status byte and an extended status byte. It hands accepted program jobs to an internal write-state model. That model waits a fixed number of cycles to stand in for cell timing, then updates a behavioural memory array. Programming can only clear bits: a cell becomes old AND new. Erase sets words back to FFh.

Two inputs are sampled as levels: a write-protect pin and a program-voltage-good flag. Together with a per-block lock vector, they decide whether a job may touch the array. Reads return one of three things, set by the read mode: the array word at `rd_addr`, the status byte, or the extended status byte.

Top module: `flash_cmd_seq`

The sequencer has these states:
- ST_IDLE: decodes commands.
- ST_PGM_SETUP: waits for the address/data write of a single program.
- ST_PGM_WAIT: holds that word until a buffer slot is free.
- ST_BUF_COUNT: takes the word count of a buffered write.
- ST_BUF_DATA: takes the start and later address/data writes.
- ST_BUF_CONFIRM: expects the confirm code.
- ST_ERS_SETUP: expects the erase confirm.
- ST_ERS_WAIT: holds the erase until all queued programs are done.

The transitions are:
- From ST_IDLE: 40h or 10h goes to ST_PGM_SETUP. E8h goes to ST_BUF_COUNT when granted. 30h goes to ST_ERS_SETUP.
- From ST_PGM_SETUP: a clean write goes to ST_PGM_WAIT. A lock or voltage fault goes back to ST_IDLE.
- From ST_PGM_WAIT: a free slot returns the state to ST_IDLE.
- From ST_BUF_COUNT: a legal count goes to ST_BUF_DATA. An illegal count goes to ST_IDLE.
- From ST_BUF_DATA: the last legal pair goes to ST_BUF_CONFIRM. Any violation goes to ST_IDLE.
- From ST_BUF_CONFIRM: every write returns the state to ST_IDLE.
- From ST_ERS_SETUP: D0h with good voltage goes to ST_ERS_WAIT. Anything else goes to ST_IDLE.
- From ST_ERS_WAIT: the state returns to ST_IDLE once the queue and the write-state model are idle.

## Requirements
- R1: After reset the read mode is array, every word reads FFh, and no error bit is set.
- R2: The status byte is laid out as follows:
  - bit 7 is ready;
  - bit 5 is the erase/sequence error;
  - bit 4 is the program error;
  - bit 3 is the program-voltage fault;
  - bit 1 is the lock fault.

  A write of 40h or 10h, followed by an address/data write, programs that word to old AND data. Bit 7 reads 0 until the job completes, then 1.
- R3: After a program, buffer-confirm or erase command, reads return the status byte. A later FFh write returns reads to the array. Clear Status (50h) does not change the read mode.
- R4: E8h sets the read mode to extended status. Bit 7 of the extended status is 1 when the next buffer slot is free; the block then waits for a count. When bit 7 is 0, no sequence is entered and the next write is decoded as a command.
- R5: In a buffered write, the count write carries N-1 (0 to 15). N address/data writes follow, each inside [start, start+N-1]. D0h then queues them, and they are programmed.
- R6: Any write other than D0h after the last buffered pair sets status bits 4 and 5. The loaded words are discarded.
- R7: A start address whose run start+N-1 reaches into the next 32-word block sets bits 4 and 5 and aborts. A run ending on the block's last word is accepted.
- R8: A buffered address outside [start, start+N-1] sets bits 4 and 5 and aborts. So does a start address outside the block named by the E8h write.
- R9: A buffer count above 15 sets bits 4 and 5 and aborts.
- R10: While bit 4 or bit 5 is set, E8h is refused and extended status bit 7 reads 0. Only 50h clears bits 1, 3, 4 and 5.
- R11: A program or buffered write to a block whose lock bit is set, while `wp_n` is low, sets bits 1 and 4 and leaves the array unchanged. With `wp_n` high, locked blocks are programmed normally.
- R12: With `vpp_ok` low, a program sets bits 3 and 4, and an erase confirm sets bits 3 and 5. The array is not changed in either case.
- R13: Erase is 30h followed by D0h. With `wp_n` low it sets every unlocked block to FFh and leaves locked blocks unchanged; with `wp_n` high it erases all blocks. Any second write other than D0h sets bits 4 and 5.
- R14: Two buffer slots alternate. A second buffer can be granted and loaded while the first is still executing. When both slots are full, E8h is not granted. Queued jobs execute in the order they were confirmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data or command code (low 8 bits) |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array word, status or extended status, by read mode |
| wp_n | input | 1 | Write-protect level; low makes lock bits effective |
| vpp_ok | input | 1 | Program voltage above lockout |
| lock_mask | input | 2**(ADDR_W-BLK_W) | Per-block lock bits |

## Verification
The embedded properties cover several rules on every cycle:
- a slot is committed only when it is free, and popped only when it is full;
- an erase never starts while a program job is pending;
- error bits survive every write except Clear Status;
- a refused E8h leaves the sequencer idle;
- a bad confirm leaves both error bits set;
- a locked program sets the lock and program bits.

Other behaviours show only in the directed scenarios:
- the AND programming result and order-free buffered loading;
- block-crossing and window violations;
- the grant and refusal seen through the extended status;
- erase skipping locked blocks;
- ordered execution of two queued buffers.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] CMD_PGM     = 8'h40;
    localparam logic [7:0] CMD_PGM_ALT = 8'h10;
    localparam logic [7:0] CMD_BUF     = 8'hE8;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_CLR     = 8'h50;
    localparam logic [7:0] CMD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_ERASE   = 8'h30;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PGM_SETUP,
        ST_PGM_WAIT,
        ST_BUF_COUNT,
        ST_BUF_DATA,
        ST_BUF_CONFIRM,
        ST_ERS_SETUP,
        ST_ERS_WAIT
    } seq_state_t;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_STATUS,
        RM_XSTATUS
    } rd_mode_t;

    typedef enum logic [1:0] {
        W_IDLE,
        W_PROG,
        W_ERASE
    } wsm_state_t;

endpackage

// File: rtl/flash_wbuf.sv
module flash_wbuf #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fill_clr,
    input  logic                    fill_we,
    input  logic [IDX_W-1:0]        fill_idx,
    input  logic [DATA_W-1:0]       fill_data,
    input  logic                    commit,
    input  logic [ADDR_W-1:0]       commit_base,
    input  logic                    pop,
    output logic                    slot_free,
    output logic                    any_full,
    output logic                    head_full,
    output logic [ADDR_W-1:0]       head_base,
    output logic [DEPTH-1:0]        head_mask,
    output logic [DEPTH*DATA_W-1:0] head_data
);

    logic [DATA_W-1:0] store_q [2][DEPTH];
    logic [DEPTH-1:0]  mask_q  [2];
    logic [ADDR_W-1:0] base_q  [2];
    logic [1:0]        full_q;
    logic              fill_ptr_q;
    logic              exec_ptr_q;
    logic [DEPTH-1:0]  idx_oh;

    assign idx_oh    = {{(DEPTH-1){1'b0}}, 1'b1} << fill_idx;
    assign slot_free = !full_q[fill_ptr_q];
    assign any_full  = |full_q;
    assign head_full = full_q[exec_ptr_q];
    assign head_base = base_q[exec_ptr_q];
    assign head_mask = mask_q[exec_ptr_q];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_head
            assign head_data[g*DATA_W +: DATA_W] = store_q[exec_ptr_q][g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (fill_we) begin
            store_q[fill_ptr_q][fill_idx] <= fill_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q[0]  <= '0;
            mask_q[1]  <= '0;
            base_q[0]  <= '0;
            base_q[1]  <= '0;
            full_q     <= '0;
            fill_ptr_q <= 1'b0;
            exec_ptr_q <= 1'b0;
        end else begin
            if (fill_clr) begin
                mask_q[fill_ptr_q] <= fill_we ? idx_oh : '0;
            end else if (fill_we) begin
                mask_q[fill_ptr_q] <= mask_q[fill_ptr_q] | idx_oh;
            end
            if (commit) begin
                full_q[fill_ptr_q] <= 1'b1;
                base_q[fill_ptr_q] <= commit_base;
                fill_ptr_q         <= ~fill_ptr_q;
            end
            if (pop) begin
                full_q[exec_ptr_q] <= 1'b0;
                exec_ptr_q         <= ~exec_ptr_q;
            end
        end
    end

    assert_commit_free_slot_R14: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !full_q[fill_ptr_q]);

    assert_pop_full_slot_R14: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> full_q[exec_ptr_q]);

endmodule

// File: rtl/flash_wsm.sv
module flash_wsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int BLK_W     = 5,
    parameter int DEPTH     = 16,
    parameter int PROG_CYC  = 20,
    parameter int ERASE_CYC = 30,
    localparam int NUM_BLK  = 1 << (ADDR_W - BLK_W),
    localparam int WORDS    = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    job_ready,
    input  logic [ADDR_W-1:0]       job_base,
    input  logic [DEPTH-1:0]        job_mask,
    input  logic [DEPTH*DATA_W-1:0] job_data,
    output logic                    job_pop,
    input  logic                    erase_go,
    input  logic [NUM_BLK-1:0]      erase_keep,
    output logic                    busy,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_word
);

    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    wsm_state_t        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [NUM_BLK-1:0] keep_q;
    logic [DATA_W-1:0] cells_q [WORDS];
    logic              erase_done;

    assign busy       = (state_q != W_IDLE);
    assign job_pop    = (state_q == W_PROG) && (cnt_q == '0);
    assign erase_done = (state_q == W_ERASE) && (cnt_q == '0);
    assign rd_word    = cells_q[rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            cnt_q   <= '0;
            keep_q  <= '0;
        end else begin
            unique case (state_q)
                W_IDLE: begin
                    if (erase_go) begin
                        state_q <= W_ERASE;
                        cnt_q   <= CNT_W'(ERASE_CYC - 1);
                        keep_q  <= erase_keep;
                    end else if (job_ready) begin
                        state_q <= W_PROG;
                        cnt_q   <= CNT_W'(PROG_CYC - 1);
                    end
                end
                W_PROG, W_ERASE: begin
                    if (cnt_q == '0) begin
                        state_q <= W_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= W_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < WORDS; a++) begin
                cells_q[a] <= '1;
            end
        end else if (job_pop) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (job_mask[i]) begin
                    cells_q[job_base + ADDR_W'(i)] <=
                        cells_q[job_base + ADDR_W'(i)] & job_data[i*DATA_W +: DATA_W];
                end
            end
        end else if (erase_done) begin
            for (int a = 0; a < WORDS; a++) begin
                if (!keep_q[a >> BLK_W]) begin
                    cells_q[a] <= '1;
                end
            end
        end
    end

    assert_erase_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> (state_q == W_IDLE && !job_ready));

    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q < CNT_W'(MAX_CYC)));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int BLK_W     = 5,
    parameter int BUF_DEPTH = 16,
    parameter int PROG_CYC  = 20,
    parameter int ERASE_CYC = 30
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [DATA_W-1:0]                   wr_data,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic [DATA_W-1:0]                   rd_data,
    input  logic                                wp_n,
    input  logic                                vpp_ok,
    input  logic [(1 << (ADDR_W - BLK_W))-1:0]  lock_mask
);

    localparam int NUM_BLK = 1 << (ADDR_W - BLK_W);
    localparam int BLKN_W  = ADDR_W - BLK_W;
    localparam int IDX_W   = $clog2(BUF_DEPTH);

    seq_state_t        state_q, state_d;
    rd_mode_t          mode_q, mode_d;
    logic              err_lock_q, err_vpp_q, err_pgm_q, err_ers_q;
    logic              set_lock, set_vpp, set_pgm, set_ers, clr_err;
    logic [BLKN_W-1:0] blk_q;
    logic              load_blk;
    logic [IDX_W-1:0]  cnt_m1_q;
    logic              load_cnt;
    logic [ADDR_W-1:0] start_q;
    logic              load_start;
    logic [IDX_W-1:0]  seen_q;
    logic              seen_clr, seen_inc;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [DATA_W-1:0] pend_data_q;
    logic              load_pend;

    logic              fill_clr, fill_we, commit, pop, erase_go;
    logic [IDX_W-1:0]  fill_idx;
    logic [DATA_W-1:0] fill_data;
    logic [ADDR_W-1:0] commit_base;
    logic              slot_free, any_full, head_full, wsm_busy;
    logic [ADDR_W-1:0] head_base;
    logic [BUF_DEPTH-1:0] head_mask;
    logic [BUF_DEPTH*DATA_W-1:0] head_data;
    logic [DATA_W-1:0] arr_word;

    logic [7:0]        cmd;
    logic [BLKN_W-1:0] wr_blk;
    logic [BLK_W:0]    run_end;
    logic [ADDR_W-1:0] delta;
    logic              err_any, ready, xsr_free;
    logic [7:0]        sr, xsr;

    assign cmd      = wr_data[7:0];
    assign wr_blk   = wr_addr[ADDR_W-1:BLK_W];
    assign run_end  = {1'b0, wr_addr[BLK_W-1:0]} + (BLK_W+1)'(cnt_m1_q);
    assign delta    = wr_addr - start_q;
    assign err_any  = err_pgm_q || err_ers_q;
    assign xsr_free = slot_free && !err_any;
    assign ready    = !wsm_busy && !any_full &&
                      (state_q != ST_PGM_WAIT) && (state_q != ST_ERS_WAIT);
    assign sr       = {ready, 1'b0, err_ers_q, err_pgm_q, err_vpp_q, 1'b0, err_lock_q, 1'b0};
    assign xsr      = {xsr_free, 7'b0};

    always_comb begin
        unique case (mode_q)
            RM_ARRAY:   rd_data = arr_word;
            RM_STATUS:  rd_data = DATA_W'(sr);
            RM_XSTATUS: rd_data = DATA_W'(xsr);
            default:    rd_data = arr_word;
        endcase
    end

    flash_wbuf #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (BUF_DEPTH)
    ) u_wbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_clr    (fill_clr),
        .fill_we     (fill_we),
        .fill_idx    (fill_idx),
        .fill_data   (fill_data),
        .commit      (commit),
        .commit_base (commit_base),
        .pop         (pop),
        .slot_free   (slot_free),
        .any_full    (any_full),
        .head_full   (head_full),
        .head_base   (head_base),
        .head_mask   (head_mask),
        .head_data   (head_data)
    );

    flash_wsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BLK_W     (BLK_W),
        .DEPTH     (BUF_DEPTH),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_wsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .job_ready  (head_full),
        .job_base   (head_base),
        .job_mask   (head_mask),
        .job_data   (head_data),
        .job_pop    (pop),
        .erase_go   (erase_go),
        .erase_keep (wp_n ? {NUM_BLK{1'b0}} : lock_mask),
        .busy       (wsm_busy),
        .rd_addr    (rd_addr),
        .rd_word    (arr_word)
    );

    // Next-state and control decode
    always_comb begin
        state_d     = state_q;
        mode_d      = mode_q;
        set_lock    = 1'b0;
        set_vpp     = 1'b0;
        set_pgm     = 1'b0;
        set_ers     = 1'b0;
        clr_err     = 1'b0;
        load_blk    = 1'b0;
        load_cnt    = 1'b0;
        load_start  = 1'b0;
        load_pend   = 1'b0;
        seen_clr    = 1'b0;
        seen_inc    = 1'b0;
        fill_clr    = 1'b0;
        fill_we     = 1'b0;
        fill_idx    = '0;
        fill_data   = wr_data;
        commit      = 1'b0;
        commit_base = start_q;
        erase_go    = 1'b0;

        unique case (state_q)
            ST_IDLE: begin
                if (wr_en) begin
                    if (cmd == CMD_PGM || cmd == CMD_PGM_ALT) begin
                        state_d = ST_PGM_SETUP;
                        mode_d  = RM_STATUS;
                    end else if (cmd == CMD_BUF) begin
                        mode_d = RM_XSTATUS;
                        if (xsr_free) begin
                            state_d  = ST_BUF_COUNT;
                            load_blk = 1'b1;
                        end
                    end else if (cmd == CMD_ERASE) begin
                        state_d = ST_ERS_SETUP;
                        mode_d  = RM_STATUS;
                    end else if (cmd == CMD_CLR) begin
                        clr_err = 1'b1;
                    end else if (cmd == CMD_ARRAY) begin
                        mode_d = RM_ARRAY;
                    end
                end
            end
            ST_PGM_SETUP: begin
                if (wr_en) begin
                    load_pend = 1'b1;
                    if (!vpp_ok) begin
                        set_vpp = 1'b1;
                        set_pgm = 1'b1;
                        state_d = ST_IDLE;
                    end else if (lock_mask[wr_blk] && !wp_n) begin
                        set_lock = 1'b1;
                        set_pgm  = 1'b1;
                        state_d  = ST_IDLE;
                    end else begin
                        state_d = ST_PGM_WAIT;
                    end
                end
            end
            ST_PGM_WAIT: begin
                if (slot_free) begin
                    fill_clr    = 1'b1;
                    fill_we     = 1'b1;
                    fill_data   = pend_data_q;
                    commit      = 1'b1;
                    commit_base = pend_addr_q;
                    state_d     = ST_IDLE;
                end
            end
            ST_BUF_COUNT: begin
                if (wr_en) begin
                    if (wr_data > DATA_W'(BUF_DEPTH - 1)) begin
                        set_pgm = 1'b1;
                        set_ers = 1'b1;
                        mode_d  = RM_STATUS;
                        state_d = ST_IDLE;
                    end else begin
                        load_cnt = 1'b1;
                        seen_clr = 1'b1;
                        fill_clr = 1'b1;
                        state_d  = ST_BUF_DATA;
                    end
                end
            end
            ST_BUF_DATA: begin
                if (wr_en) begin
                    if (seen_q == '0) begin
                        if (wr_blk != blk_q || run_end[BLK_W]) begin
                            set_pgm = 1'b1;
                            set_ers = 1'b1;
                            mode_d  = RM_STATUS;
                            state_d = ST_IDLE;
                        end else begin
                            load_start = 1'b1;
                            fill_we    = 1'b1;
                            fill_idx   = '0;
                            seen_inc   = 1'b1;
                            if (cnt_m1_q == '0) begin
                                state_d = ST_BUF_CONFIRM;
                            end
                        end
                    end else if (wr_addr < start_q || delta > ADDR_W'(cnt_m1_q)) begin
                        set_pgm = 1'b1;
                        set_ers = 1'b1;
                        mode_d  = RM_STATUS;
                        state_d = ST_IDLE;
                    end else begin
                        fill_we  = 1'b1;
                        fill_idx = delta[IDX_W-1:0];
                        seen_inc = 1'b1;
                        if (seen_q == cnt_m1_q) begin
                            state_d = ST_BUF_CONFIRM;
                        end
                    end
                end
            end
            ST_BUF_CONFIRM: begin
                if (wr_en) begin
                    mode_d  = RM_STATUS;
                    state_d = ST_IDLE;
                    if (cmd != CMD_CONFIRM) begin
                        set_pgm = 1'b1;
                        set_ers = 1'b1;
                    end else if (!vpp_ok) begin
                        set_vpp = 1'b1;
                        set_pgm = 1'b1;
                    end else if (lock_mask[blk_q] && !wp_n) begin
                        set_lock = 1'b1;
                        set_pgm  = 1'b1;
                    end else begin
                        commit = 1'b1;
                    end
                end
            end
            ST_ERS_SETUP: begin
                if (wr_en) begin
                    if (cmd != CMD_CONFIRM) begin
                        set_pgm = 1'b1;
                        set_ers = 1'b1;
                        state_d = ST_IDLE;
                    end else if (!vpp_ok) begin
                        set_vpp = 1'b1;
                        set_ers = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_ERS_WAIT;
                    end
                end
            end
            ST_ERS_WAIT: begin
                if (!wsm_busy && !any_full) begin
                    erase_go = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
        endcase
    end

    // State and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            mode_q      <= RM_ARRAY;
            err_lock_q  <= 1'b0;
            err_vpp_q   <= 1'b0;
            err_pgm_q   <= 1'b0;
            err_ers_q   <= 1'b0;
            blk_q       <= '0;
            cnt_m1_q    <= '0;
            start_q     <= '0;
            seen_q      <= '0;
            pend_addr_q <= '0;
            pend_data_q <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            if (clr_err) begin
                err_lock_q <= 1'b0;
                err_vpp_q  <= 1'b0;
                err_pgm_q  <= 1'b0;
                err_ers_q  <= 1'b0;
            end else begin
                err_lock_q <= err_lock_q | set_lock;
                err_vpp_q  <= err_vpp_q  | set_vpp;
                err_pgm_q  <= err_pgm_q  | set_pgm;
                err_ers_q  <= err_ers_q  | set_ers;
            end
            if (load_blk)   blk_q    <= wr_blk;
            if (load_cnt)   cnt_m1_q <= wr_data[IDX_W-1:0];
            if (load_start) start_q  <= wr_addr;
            if (seen_clr)      seen_q <= '0;
            else if (seen_inc) seen_q <= seen_q + 1'b1;
            if (load_pend) begin
                pend_addr_q <= wr_addr;
                pend_data_q <= wr_data;
            end
        end
    end

    assert_refuse_buffer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && wr_en && cmd == CMD_BUF && err_any) |=> (state_q == ST_IDLE));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pgm_q && !(state_q == ST_IDLE && wr_en && cmd == CMD_CLR)) |=> err_pgm_q);

    assert_bad_confirm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUF_CONFIRM && wr_en && cmd != CMD_CONFIRM)
            |=> (err_pgm_q && err_ers_q && state_q == ST_IDLE));

    assert_locked_program_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PGM_SETUP && wr_en && vpp_ok && lock_mask[wr_blk] && !wp_n)
            |=> (err_lock_q && err_pgm_q));

endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wp_n = 1'b1;
    logic       vpp_ok = 1'b1;
    logic [7:0] lock_mask = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    flash_cmd_seq u_flash_cmd_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wp_n      (wp_n),
        .vpp_ok    (vpp_ok),
        .lock_mask (lock_mask)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_ready();
        logic [7:0] v;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            rd(8'h00, v);
            if (v[7]) break;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(8'h00, v); check("R1 cell 00 after reset", v, 8'hFF);
        rd(8'hC3, v); check("R1 cell C3 after reset", v, 8'hFF);
    endtask

    task automatic t_program();
        logic [7:0] v;
        wr(8'h00, 8'h40);
        wr(8'h05, 8'hA5);
        rd(8'h05, v); check("R2 busy right after program", v & 8'h80, 8'h00);
        wait_ready();
        rd(8'h05, v); check("R3 status mode after program", v, 8'h80);
        wr(8'h00, 8'hFF);
        rd(8'h05, v); check("R2 word programmed", v, 8'hA5);
        wr(8'h00, 8'h10);
        wr(8'h05, 8'h0F);
        wait_ready();
        wr(8'h00, 8'h50);
        rd(8'h05, v); check("R3 clear keeps status mode", v, 8'h80);
        wr(8'h00, 8'hFF);
        rd(8'h05, v); check("R2 alt code ANDs bits", v, 8'h05);
    endtask

    task automatic t_buffer();
        logic [7:0] v;
        wr(8'h20, 8'hE8);
        rd(8'h00, v); check("R4 buffer granted", v, 8'h80);
        wr(8'h20, 8'h03);
        wr(8'h22, 8'h11);
        wr(8'h23, 8'h22);
        wr(8'h25, 8'h44);
        wr(8'h24, 8'h33);
        wr(8'h20, 8'hD0);
        wait_ready();
        rd(8'h00, v); check("R5 status after buffer", v, 8'h80);
        wr(8'h00, 8'hFF);
        rd(8'h22, v); check("R5 buffered word 22", v, 8'h11);
        rd(8'h24, v); check("R5 buffered word 24", v, 8'h33);
        rd(8'h25, v); check("R5 buffered word 25", v, 8'h44);
    endtask

    task automatic t_bad_confirm();
        logic [7:0] v;
        wr(8'h40, 8'hE8);
        wr(8'h40, 8'h00);
        wr(8'h40, 8'h00);
        wr(8'h40, 8'hFF);
        rd(8'h00, v); check("R6 bad confirm sets 4 and 5", v, 8'hB0);
        wr(8'h40, 8'hE8);
        rd(8'h00, v); check("R10 buffer refused while error", v, 8'h00);
        wr(8'h00, 8'h50);
        wr(8'h40, 8'hE8);
        rd(8'h00, v); check("R10 granted after clear", v, 8'h80);
        wr(8'h40, 8'h00);
        wr(8'h41, 8'h3C);
        wr(8'h40, 8'hD0);
        wait_ready();
        wr(8'h00, 8'hFF);
        rd(8'h40, v); check("R6 discarded words untouched", v, 8'hFF);
        rd(8'h41, v); check("R10 program after clear", v, 8'h3C);
    endtask

    task automatic t_cross();
        logic [7:0] v;
        wr(8'h60, 8'hE8);
        wr(8'h60, 8'h03);
        wr(8'h7E, 8'h00);
        rd(8'h00, v); check("R7 block cross aborts", v, 8'hB0);
        wr(8'h00, 8'h50);
        wr(8'h60, 8'hE8);
        wr(8'h60, 8'h01);
        wr(8'h7E, 8'h12);
        wr(8'h7F, 8'h34);
        wr(8'h60, 8'hD0);
        wait_ready();
        rd(8'h00, v); check("R7 run ending on last word ok", v, 8'h80);
        wr(8'h00, 8'hFF);
        rd(8'h7F, v); check("R7 last word of block", v, 8'h34);
    endtask

    task automatic t_window();
        logic [7:0] v;
        wr(8'h80, 8'hE8);
        wr(8'h80, 8'h01);
        wr(8'h80, 8'h00);
        wr(8'h82, 8'h00);
        rd(8'h00, v); check("R8 address outside window", v, 8'hB0);
        wr(8'h00, 8'h50);
        wr(8'h80, 8'hE8);
        wr(8'h80, 8'h00);
        wr(8'hA0, 8'h00);
        rd(8'h00, v); check("R8 start in other block", v, 8'hB0);
        wr(8'h00, 8'h50);
        wr(8'h80, 8'hE8);
        wr(8'h80, 8'h10);
        rd(8'h00, v); check("R9 count above 15", v, 8'hB0);
        wr(8'h00, 8'h50);
        wr(8'h00, 8'hFF);
        rd(8'h80, v); check("R8 aborted words untouched", v, 8'hFF);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        lock_mask = 8'h10;
        wp_n = 1'b0;
        wr(8'h00, 8'h40);
        wr(8'h85, 8'h00);
        rd(8'h00, v); check("R11 locked program flags", v, 8'h92);
        wr(8'h00, 8'h50);
        wr(8'h88, 8'hE8);
        wr(8'h88, 8'h00);
        wr(8'h88, 8'h00);
        wr(8'h88, 8'hD0);
        rd(8'h00, v); check("R11 locked buffer flags", v, 8'h92);
        wr(8'h00, 8'h50);
        wr(8'h00, 8'hFF);
        rd(8'h85, v); check("R11 locked word unchanged", v, 8'hFF);
        wp_n = 1'b1;
        wr(8'h00, 8'h40);
        wr(8'h85, 8'h00);
        wait_ready();
        wr(8'h00, 8'hFF);
        rd(8'h85, v); check("R11 wp high programs locked block", v, 8'h00);
    endtask

    task automatic t_vpp();
        logic [7:0] v;
        vpp_ok = 1'b0;
        wr(8'h00, 8'h40);
        wr(8'h06, 8'h00);
        rd(8'h00, v); check("R12 program low voltage", v, 8'h98);
        wr(8'h00, 8'h50);
        wr(8'h00, 8'h30);
        wr(8'h00, 8'hD0);
        rd(8'h00, v); check("R12 erase low voltage", v, 8'hA8);
        wr(8'h00, 8'h50);
        vpp_ok = 1'b1;
        wr(8'h00, 8'hFF);
        rd(8'h06, v); check("R12 word unchanged", v, 8'hFF);
    endtask

    task automatic t_erase();
        logic [7:0] v;
        wp_n = 1'b0;
        wr(8'h00, 8'h30);
        wr(8'h00, 8'hD0);
        wait_ready();
        rd(8'h00, v); check("R13 erase completes", v, 8'h80);
        wr(8'h00, 8'hFF);
        rd(8'h05, v); check("R13 unlocked block erased", v, 8'hFF);
        rd(8'h85, v); check("R13 locked block kept", v, 8'h00);
        wr(8'h00, 8'h30);
        wr(8'h00, 8'h40);
        rd(8'h00, v); check("R13 bad erase confirm", v, 8'hB0);
        wr(8'h00, 8'h50);
        wp_n = 1'b1;
        wr(8'h00, 8'h30);
        wr(8'h00, 8'hD0);
        wait_ready();
        wr(8'h00, 8'hFF);
        rd(8'h85, v); check("R13 wp high erases all", v, 8'hFF);
        lock_mask = 8'h00;
    endtask

    task automatic t_two_slots();
        logic [7:0] v;
        wr(8'h00, 8'hE8);
        wr(8'h00, 8'h00);
        wr(8'h10, 8'hF0);
        wr(8'h00, 8'hD0);
        wr(8'h00, 8'hE8);
        rd(8'h00, v); check("R14 second slot granted while busy", v, 8'h80);
        wr(8'h00, 8'h00);
        wr(8'h10, 8'h3F);
        wr(8'h00, 8'hD0);
        wr(8'h00, 8'hE8);
        rd(8'h00, v); check("R4 both slots full refuses", v, 8'h00);
        repeat (150) @(negedge clk);
        wr(8'h00, 8'hFF);
        rd(8'h10, v); check("R14 both jobs applied in order", v, 8'h30);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_buffer();
        t_bad_confirm();
        t_cross();
        t_window();
        t_lock();
        t_vpp();
        t_erase();
        t_two_slots();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog R1 actual=%h expected=%h", 8'h00, 8'h01);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule